// File: doc/BRIEF.md
# Clocked Parallel EEPROM Emulator

This block stands in for a byte-wide parallel EEPROM inside a synchronous design. Three active-low control pins (chip enable, output enable, write enable) are sampled on the system clock and decoded into four modes: read, standby, byte write and write inhibit. Reads return the addressed byte one clock after the read mode is seen. Writes go to a page buffer first. The array itself only changes during a self-timed programming period.

Bytes that land in the same page are gathered for as long as each new byte arrives inside a load window. When the window runs out, a programming period of fixed length starts. During that period every write is ignored, and a read returns a status word instead of array data. In that word, bit 7 is the complement of bit 7 of the last byte accepted, and bit 6 inverts from one read to the next. Software can poll either bit to find the end of the write.

All windows are given as clock-cycle parameters, so a simulation can shorten them. The control pins are assumed to be synchronous to the clock already.

Top module: `eeprom_emu`

## Requirements
- R1: While chip enable is low, output enable is low and write enable is high, `dout_en` is 1 and `dout` holds the byte at `addr`. Both appear one clock after the mode is sampled.
- R2: While chip enable is high, `dout_en` is 0 whatever the other two pins are.
- R3: A write mode is chip enable low, output enable high and write enable low. Address and data are captured on the first clock of that mode, which is the later of the two falling enables. The byte is offered to the page buffer on the clock after either enable rises, so changes on `addr`/`din` in between have no effect.
- R4: No write happens while output enable is low or write enable is high.
- R5: The page is `addr[ADDR_W-1:PAGE_W]` (64-byte pages by default). The first byte of a load sequence selects the page, and later bytes that address another page are dropped.
- R6: Each accepted byte restarts a window of `LOAD_WIN` clocks. When the window expires with no new byte, programming starts. Until then the array keeps its old contents.
- R7: Programming lasts `WRITE_CYC` clocks, and every write offered during it is ignored.
- R8: A read during programming returns bit 7 inverted and bits 5..0 unchanged from the last byte accepted into the page buffer.
- R9: In that status word, bit 6 is 0 on the first read of a programming period and inverts after each read ends.
- R10: After programming, reads return the programmed bytes, and bytes never written read 0xFF.
- R11: After reset, `dout_en` and `dout` are 0 and every array byte is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or status word |
| dout_en | output | 1 | High while the data bus would be driven |

## Verification
The hardest state to reach from the ports is a second read inside one programming period. It needs a filled page, a window that has really expired, and then two reads that both fit before programming ends. The stimulus shortens both windows through parameters and counts clocks from the last accepted byte. This places two reads, and one ignored write, inside the busy period. Window restart is shown by a second byte sent just before expiry: a read after it still sees the old array contents, and no status word appears.

// File: rtl/eeprom_emu_pkg.sv
// Shared types for the parallel EEPROM emulator.
// Assumes: nothing beyond IEEE 1800-2017.
package eeprom_emu_pkg;

    // Decoded state of the three control pins.
    typedef enum logic [1:0] {
        PIN_STANDBY = 2'd0,
        PIN_READ    = 2'd1,
        PIN_WRITE   = 2'd2,
        PIN_INHIBIT = 2'd3
    } pin_mode_e;

    // Page loader state.
    typedef enum logic [1:0] {
        LD_IDLE = 2'd0,
        LD_FILL = 2'd1,
        LD_BURN = 2'd2
    } load_state_e;

    // Map active-low pins onto a mode; chip enable high wins over all.
    function automatic pin_mode_e decode_pins(input logic ce_n,
                                              input logic oe_n,
                                              input logic we_n);
        pin_mode_e m;
        if (ce_n)                m = PIN_STANDBY;
        else if (!oe_n && we_n)  m = PIN_READ;
        else if (oe_n && !we_n)  m = PIN_WRITE;
        else                     m = PIN_INHIBIT;
        return m;
    endfunction

endpackage

// File: rtl/eeprom_emu_ctrl.sv
// Control pin front end.
// What it does: decodes chip enable, output enable and write enable into a
// mode. It captures address and data on the first clock of a write mode and
// emits a one-cycle commit when that mode ends. It also flags the end of each read.
// Assumes: pins are already synchronous to clk.
module eeprom_emu_ctrl
    import eeprom_emu_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output pin_mode_e         mode,
    output logic              commit_vld,
    output logic [ADDR_W-1:0] commit_addr,
    output logic [7:0]        commit_data,
    output logic              rd_end
);

    pin_mode_e         prev_mode;
    logic              wr_start;
    logic [ADDR_W-1:0] lat_addr;
    logic [7:0]        lat_data;

    // Current mode straight from the pins.
    always_comb mode = decode_pins(ce_n, oe_n, we_n);

    // Mode transitions: start and end of write, end of read.
    always_comb begin
        wr_start   = (mode == PIN_WRITE) && (prev_mode != PIN_WRITE);
        commit_vld = (prev_mode == PIN_WRITE) && (mode != PIN_WRITE);
        rd_end     = (prev_mode == PIN_READ) && (mode != PIN_READ);
    end

    // Remember the mode of the previous clock.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_mode <= PIN_STANDBY;
        else        prev_mode <= mode;
    end

    // Capture address and data when the later enable has fallen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_addr <= '0;
            lat_data <= '0;
        end else if (wr_start) begin
            lat_addr <= addr;
            lat_data <= din;
        end
    end

    always_comb begin
        commit_addr = lat_addr;
        commit_data = lat_data;
    end

    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_mode == PIN_WRITE && mode == PIN_WRITE) |=> $stable(lat_addr) && $stable(lat_data)); // R3

endmodule

// File: rtl/eeprom_emu_page.sv
// Page buffer, load window and programming sequencer.
// What it does: gathers accepted bytes of one page into a buffer. It restarts
// a load window for each byte. When the window expires, it runs a busy period
// of WRITE_CYC clocks, copying one buffer slot per clock into the array.
// Assumes: WRITE_CYC >= 2**PAGE_W and LOAD_WIN >= 1.
module eeprom_emu_page
    import eeprom_emu_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int PAGE_W    = 6,
    parameter int LOAD_WIN  = 37000,
    parameter int WRITE_CYC = 2500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_vld,
    input  logic [ADDR_W-1:0] commit_addr,
    input  logic [7:0]        commit_data,
    output logic              busy,
    output logic [7:0]        last_byte,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [7:0]        mem_wdata
);

    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int PG_W       = ADDR_W - PAGE_W;
    localparam int TMR_W      = $clog2(LOAD_WIN + 1);
    localparam int BRN_W      = $clog2(WRITE_CYC + 1);
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(LOAD_WIN - 1);
    localparam logic [BRN_W-1:0] BRN_LAST = BRN_W'(WRITE_CYC - 1);
    localparam logic [BRN_W-1:0] BRN_PAGE = BRN_W'(PAGE_BYTES);

    load_state_e       st;
    logic [PG_W-1:0]   page_q;
    logic [TMR_W-1:0]  timer;
    logic [BRN_W-1:0]  burn_cnt;
    logic [7:0]        last_q;
    logic [7:0]        pbuf     [PAGE_BYTES];
    logic              slot_vld [PAGE_BYTES];
    logic              accept;
    logic              burn_last;
    logic [PAGE_W-1:0] in_slot;
    logic [PAGE_W-1:0] out_slot;
    logic [PG_W-1:0]   in_page;

    // Split the incoming address into page and slot.
    always_comb begin
        in_page  = commit_addr[ADDR_W-1:PAGE_W];
        in_slot  = commit_addr[PAGE_W-1:0];
        out_slot = burn_cnt[PAGE_W-1:0];
    end

    // A byte is accepted when idle, or when filling the same page.
    always_comb begin
        accept    = commit_vld && ((st == LD_IDLE) ||
                                   (st == LD_FILL && in_page == page_q));
        burn_last = (st == LD_BURN) && (burn_cnt == BRN_LAST);
    end

    // Loader state, load window timer and programming counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= LD_IDLE;
            timer    <= '0;
            burn_cnt <= '0;
        end else begin
            case (st)
                LD_IDLE: begin
                    if (accept) begin
                        st    <= LD_FILL;
                        timer <= '0;
                    end
                end
                LD_FILL: begin
                    if (accept) begin
                        timer <= '0;
                    end else if (timer == TMR_LAST) begin
                        st       <= LD_BURN;
                        burn_cnt <= '0;
                    end else begin
                        timer <= timer + 1'b1;
                    end
                end
                LD_BURN: begin
                    if (burn_last) st <= LD_IDLE;
                    else           burn_cnt <= burn_cnt + 1'b1;
                end
                default: st <= LD_IDLE;
            endcase
        end
    end

    // Page selected by the first byte, and last accepted byte for polling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
            last_q <= '0;
        end else if (accept) begin
            if (st == LD_IDLE) page_q <= in_page;
            last_q <= commit_data;
        end
    end

    // One data register and one valid flag per page slot.
    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        // Store the byte for this slot; clear the flag after programming.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pbuf[g]     <= '0;
                slot_vld[g] <= 1'b0;
            end else if (burn_last) begin
                slot_vld[g] <= 1'b0;
            end else if (accept && in_slot == PAGE_W'(g)) begin
                pbuf[g]     <= commit_data;
                slot_vld[g] <= 1'b1;
            end
        end
    end

    // Array write port: one slot per clock during the first PAGE_BYTES clocks.
    always_comb begin
        mem_we    = (st == LD_BURN) && (burn_cnt < BRN_PAGE) && slot_vld[out_slot];
        mem_waddr = {page_q, out_slot};
        mem_wdata = pbuf[out_slot];
        busy      = (st == LD_BURN);
        last_byte = last_q;
    end

    AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st == LD_FILL) |-> (timer <= TMR_LAST)); // R6

    AST_BURN_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !burn_last) |=> $stable(page_q) && $stable(last_q)); // R7

    AST_BURN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(burn_cnt) == BRN_LAST); // R7

endmodule

// File: rtl/eeprom_emu_array.sv
// Storage array and read path.
// What it does: holds 2**ADDR_W bytes that are erased to 0xFF at reset and
// written by the sequencer. It registers the read data, or the status word
// while programming runs, and keeps the toggle bit.
// Assumes: read and array write never need the same cycle to agree.
module eeprom_emu_array #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_mode,
    input  logic              rd_end,
    input  logic [ADDR_W-1:0] raddr,
    input  logic              busy,
    input  logic [7:0]        last_byte,
    input  logic              mem_we,
    input  logic [ADDR_W-1:0] mem_waddr,
    input  logic [7:0]        mem_wdata,
    output logic [7:0]        dout,
    output logic              dout_en
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];
    logic       tgl;
    logic [7:0] poll_word;
    logic [7:0] dout_q;
    logic       dout_en_q;

    // Erase at reset, program one byte per write pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (mem_we) begin
            mem[mem_waddr] <= mem_wdata;
        end
    end

    // Toggle bit: zero when idle, inverts at the end of each busy read.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) tgl <= 1'b0;
        else if (rd_end)     tgl <= ~tgl;
    end

    // Status word shown while programming.
    always_comb poll_word = {~last_byte[7], tgl, last_byte[5:0]};

    // Registered read path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q    <= '0;
            dout_en_q <= 1'b0;
        end else begin
            dout_en_q <= rd_mode;
            if (rd_mode) dout_q <= busy ? poll_word : mem[raddr];
        end
    end

    always_comb begin
        dout    = dout_q;
        dout_en = dout_en_q;
    end

    AST_WRITE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy); // R7

    AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_end) |=> (tgl != $past(tgl)) || !busy); // R9

endmodule

// File: rtl/eeprom_emu.sv
// Top level of the parallel EEPROM emulator.
// What it does: connects the pin front end, the page loader and the array.
// Assumes: pins synchronous to clk; LOAD_WIN and WRITE_CYC given in clocks.
module eeprom_emu
    import eeprom_emu_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int PAGE_W    = 6,
    parameter int LOAD_WIN  = 37000,
    parameter int WRITE_CYC = 2500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_en
);

    pin_mode_e         mode;
    logic              commit_vld;
    logic [ADDR_W-1:0] commit_addr;
    logic [7:0]        commit_data;
    logic              rd_end;
    logic              busy;
    logic [7:0]        last_byte;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [7:0]        mem_wdata;
    logic              rd_mode;

    // Read enable for the array.
    always_comb rd_mode = (mode == PIN_READ);

    eeprom_emu_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .ce_n        (ce_n),
        .oe_n        (oe_n),
        .we_n        (we_n),
        .addr        (addr),
        .din         (din),
        .mode        (mode),
        .commit_vld  (commit_vld),
        .commit_addr (commit_addr),
        .commit_data (commit_data),
        .rd_end      (rd_end)
    );

    eeprom_emu_page #(
        .ADDR_W    (ADDR_W),
        .PAGE_W    (PAGE_W),
        .LOAD_WIN  (LOAD_WIN),
        .WRITE_CYC (WRITE_CYC)
    ) u_page (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit_vld  (commit_vld),
        .commit_addr (commit_addr),
        .commit_data (commit_data),
        .busy        (busy),
        .last_byte   (last_byte),
        .mem_we      (mem_we),
        .mem_waddr   (mem_waddr),
        .mem_wdata   (mem_wdata)
    );

    eeprom_emu_array #(.ADDR_W(ADDR_W)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_mode   (rd_mode),
        .rd_end    (rd_end),
        .raddr     (addr),
        .busy      (busy),
        .last_byte (last_byte),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata),
        .dout      (dout),
        .dout_en   (dout_en)
    );

    AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ce_n) |-> !dout_en); // R2

    AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && we_n) |=> dout_en); // R1

endmodule

// File: tb/eeprom_emu_bench.sv
// Self-checking bench: a vector table walked by one loop, then directed tests.
module eeprom_emu_bench;

    localparam int AW = 8;
    localparam int LW = 20;
    localparam int WC = 100;

    // Vector: op[1:0], addr[7:0], data[7:0], expected[7:0]
    // op 0 write, 1 read, 2 wait (data = clocks), 3 write attempt with OE low
    localparam int NV = 16;
    localparam logic [25:0] VEC [NV] = '{
        {2'd0, 8'h05, 8'h3C, 8'h00},   // R3 accepted byte, page 0
        {2'd0, 8'h06, 8'hA5, 8'h00},   // R5 same page
        {2'd0, 8'h47, 8'h11, 8'h00},   // R5 other page, dropped
        {2'd1, 8'h05, 8'h00, 8'hFF},   // R6 window still open, old contents
        {2'd2, 8'h00, 8'd25, 8'h00},   // R6 let window expire
        {2'd1, 8'h05, 8'h00, 8'h25},   // R8 status word of 0xA5, bit6 0
        {2'd1, 8'h05, 8'h00, 8'h65},   // R9 second read, bit6 1
        {2'd0, 8'h10, 8'h77, 8'h00},   // R7 write while busy
        {2'd2, 8'h00, 8'd120, 8'h00},  // R7 programming completes
        {2'd1, 8'h05, 8'h00, 8'h3C},   // R10
        {2'd1, 8'h06, 8'h00, 8'hA5},   // R10
        {2'd1, 8'h47, 8'h00, 8'hFF},   // R5 dropped byte not stored
        {2'd1, 8'h10, 8'h00, 8'hFF},   // R7 busy write not stored
        {2'd3, 8'h20, 8'h5A, 8'h00},   // R4 OE low blocks write
        {2'd2, 8'h00, 8'd130, 8'h00},  // R4 wait past any programming
        {2'd1, 8'h20, 8'h00, 8'hFF}    // R4 still erased
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1;
    logic          oe_n = 1'b1;
    logic          we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = '0;
    logic [7:0]    dout;
    logic          dout_en;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    eeprom_emu #(
        .ADDR_W    (AW),
        .PAGE_W    (6),
        .LOAD_WIN  (LW),
        .WRITE_CYC (WC)
    ) u_eeprom_emu (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_n    (ce_n),
        .oe_n    (oe_n),
        .we_n    (we_n),
        .addr    (addr),
        .din     (din),
        .dout    (dout),
        .dout_en (dout_en)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [7:0] d, input logic oe_low);
        @(negedge clk);
        addr = a; din = d; oe_n = oe_low ? 1'b0 : 1'b1; ce_n = 1'b0; we_n = 1'b0;
        idle(2);
        we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_read(input logic [AW-1:0] a, output logic [7:0] d, output logic en);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        idle(2);
        d = dout; en = dout_en;
        ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] rd;
        logic       en;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11 dout_en", {7'd0, dout_en}, 8'h00);
        check("R11 dout", dout, 8'h00);
        do_read(8'hFE, rd, en);
        check("R11 erased", rd, 8'hFF);
        check("R1 dout_en in read", {7'd0, en}, 8'h01);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            logic [1:0] op;
            op = VEC[v][25:24];
            case (op)
                2'd0: do_write(VEC[v][23:16], VEC[v][15:8], 1'b0);
                2'd3: do_write(VEC[v][23:16], VEC[v][15:8], 1'b1);
                2'd2: idle(int'(VEC[v][15:8]));
                default: begin
                    do_read(VEC[v][23:16], rd, en);
                    check($sformatf("R1 vector %0d", v), rd, VEC[v][7:0]);
                end
            endcase
        end

        // R2 standby: chip enable high, others low
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b0; we_n = 1'b0;
        idle(2);
        check("R2 standby dout_en", {7'd0, dout_en}, 8'h00);
        oe_n = 1'b1; we_n = 1'b1;
        idle(1);

        // R6 window restart by a second byte before expiry
        do_write(8'h80, 8'h01, 1'b0);
        idle(10);
        do_write(8'h81, 8'h02, 1'b0);
        idle(10);
        do_read(8'h80, rd, en);
        check("R6 restart keeps window open", rd, 8'hFF);
        idle(20);
        do_read(8'h80, rd, en);
        check("R8 status of 0x02", rd, 8'h82);
        idle(WC + 20);
        do_read(8'h81, rd, en);
        check("R10 page byte 0x81", rd, 8'h02);
        do_read(8'h80, rd, en);
        check("R10 page byte 0x80", rd, 8'h01);

        // R3 chip-enable-controlled write; bus changes after capture ignored
        @(negedge clk);
        addr = 8'hC3; din = 8'h9E; oe_n = 1'b1; we_n = 1'b0; ce_n = 1'b1;
        idle(2);
        ce_n = 1'b0;
        idle(2);
        addr = 8'hC4; din = 8'h11;
        idle(2);
        ce_n = 1'b1;
        @(negedge clk);
        we_n = 1'b1;
        idle(LW + WC + 10);
        do_read(8'hC3, rd, en);
        check("R3 captured at later falling enable", rd, 8'h9E);
        do_read(8'hC4, rd, en);
        check("R3 late bus change ignored", rd, 8'hFF);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule